// File: doc/BRIEF.md
# SAR Conversion Control Sequencer

This block sequences one successive-approximation conversion. It watches a chip-select input and a read/convert input, which are active low and combined by OR. The select counts as asserted only while both inputs are low. A conversion starts at the clock edge where the select first reads asserted, so the trigger is whichever input falls second. The inputs may fall in either order.

Once a conversion has started, the block holds its busy output low. It then runs a binary search from the most significant bit down. Each step puts a trial code on the DAC output and samples a one-bit comparator. After the last bit, the block latches the code into the result register and pulses a strobe. Busy is released one cycle after that pulse. A valid flag travels with the result. The flag is low for the first conversion after reset, whose result is meaningless.

While the power-down input is high, convert commands are ignored and the stored result is kept. Convert edges that arrive while busy is low are also ignored. All inputs are assumed synchronous to the clock.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts at the clock edge where the select (cs_n OR rc_n) is sampled low after having been sampled high in the previous cycle. Either input may fall first.
- R2: busy_n goes low in the cycle after the start edge and stays low for exactly WIDTH+2 cycles. It then returns high.
- R3: result_strobe is high for one cycle, which is the last cycle of the busy-low period. result takes its new value in that same cycle, and busy_n is high in the following cycle.
- R4: The first trial code after a start is a one in the MSB only. At each step the current bit is kept if cmp_ge is 1 (input at or above the trial level) and cleared otherwise, and the next lower bit is set. The latched result is the final code after WIDTH steps.
- R5: result_valid is 0 with the first result after reset and 1 with every later result.
- R6: While pwrdn is 1, a select falling edge starts nothing, and result and result_valid keep their values. A select that fell during power-down does not start a conversion when pwrdn is released.
- R7: A select falling edge that occurs while busy_n is low is ignored.
- R8: In reset, busy_n is 1, result_strobe is 0, result_valid is 0 and result is 0.
- R9: Outside the strobe cycle, result and result_valid do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rc_n | input | 1 | Read/convert, active low |
| pwrdn | input | 1 | Power-down; high blocks conversions |
| cmp_ge | input | 1 | Comparator: 1 when the input is at or above the trial level |
| trial_code | output | WIDTH | Trial code driven to the DAC |
| busy_n | output | 1 | Low while a conversion is in progress |
| result | output | WIDTH | Latched conversion result |
| result_strobe | output | 1 | One-cycle pulse when result is updated |
| result_valid | output | 1 | Qualifies result; low for the first result after reset |

## Verification
The bench builds the block with the default WIDTH of 16. With this width it can check full 16-bit codes, including all-ones, all-zeros and the values on either side of the MSB.

The bench drives the comparator from a held analog value, so each conversion must reproduce that value exactly. The start edge is produced in both orders of the two select inputs. Extra edges are injected during a conversion, and inputs are changed around a power-down with the select held low. These cases exercise the trigger rules.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CONV    = 2'd1,
    ST_LATCH   = 2'd2,
    ST_RELEASE = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_conv_trigger.sv
module sar_conv_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rc_n,
  input  logic pwrdn,
  input  logic idle,
  output logic start
);
  logic sel_now;
  logic sel_q;

  assign sel_now = cs_n | rc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b1;
    else        sel_q <= sel_now;
  end

  // select asserted now, deasserted last cycle: second input just fell
  assign start = sel_q & ~sel_now & ~pwrdn & idle;
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] code,
  output logic             last
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] code_q, code_d;
  logic [WIDTH-1:0] mask_q, mask_d;

  always_comb begin
    code_d = code_q;
    mask_d = mask_q;
    if (load) begin
      code_d = MSB_ONLY;
      mask_d = MSB_ONLY;
    end else if (step) begin
      code_d = (cmp_ge ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (load || step) begin
      code_q <= code_d;
      mask_q <= mask_d;
    end
  end

  assign code = code_q;
  assign last = mask_q[0];
endmodule

// File: rtl/sar_result_hold.sv
module sar_result_hold #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] result,
  output logic             strobe,
  output logic             valid
);
  logic [WIDTH-1:0] result_q;
  logic             valid_q;
  logic             primed_q;
  logic             strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
      primed_q <= 1'b0;
    end else if (capture) begin
      result_q <= code;
      valid_q  <= primed_q;
      primed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= capture;
  end

  assign result = result_q;
  assign valid  = valid_q;
  assign strobe = strobe_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rc_n,
  input  logic             pwrdn,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] trial_code,
  output logic             busy_n,
  output logic [WIDTH-1:0] result,
  output logic             result_strobe,
  output logic             result_valid
);
  import sar_ctrl_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sar_state_e state_q, state_d;
  logic start, load, step, capture, last;
  logic idle;

  assign idle = (state_q == ST_IDLE);

  sar_conv_trigger u_trigger (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cs_n  (cs_n),
    .rc_n  (rc_n),
    .pwrdn (pwrdn),
    .idle  (idle),
    .start (start)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        step = 1'b1;
        if (last) state_d = ST_LATCH;
      end
      ST_LATCH: begin
        capture = 1'b1;
        state_d = ST_RELEASE;
      end
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  sar_search #(.WIDTH(WIDTH)) u_search (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (load),
    .step   (step),
    .cmp_ge (cmp_ge),
    .code   (trial_code),
    .last   (last)
  );

  sar_result_hold #(.WIDTH(WIDTH)) u_hold (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .capture (capture),
    .code    (trial_code),
    .result  (result),
    .strobe  (result_strobe),
    .valid   (result_valid)
  );

  assign busy_n = idle;
endmodule

// File: rtl/sar_conv_ctrl_checker.sv
module sar_conv_ctrl_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rc_n,
  input logic             pwrdn,
  input logic [WIDTH-1:0] trial_code,
  input logic             busy_n,
  input logic [WIDTH-1:0] result,
  input logic             result_strobe,
  input logic             result_valid
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [31:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (busy_n) low_cnt <= '0;
    else             low_cnt <= low_cnt + 32'd1;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_cnt == 32'(WIDTH + 2)));

  p_strobe_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_strobe |-> !busy_n);

  p_busy_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_strobe |=> (busy_n && !result_strobe));

  p_first_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> (trial_code == TOP_BIT));

  p_pwrdn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn && busy_n) |=> busy_n);

  p_result_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !result_strobe |-> ($stable(result) && $stable(result_valid)));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_checker #(.WIDTH(WIDTH)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_n          (cs_n),
  .rc_n          (rc_n),
  .pwrdn         (pwrdn),
  .trial_code    (trial_code),
  .busy_n        (busy_n),
  .result        (result),
  .result_strobe (result_strobe),
  .result_valid  (result_valid)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic         cs_n, rc_n, pwrdn;
  logic [W-1:0] ain;
  logic         cmp_ge;
  logic [W-1:0] trial_code, result;
  logic         busy_n, result_strobe, result_valid;

  int checks = 0;
  int errors = 0;
  string ctx = "R1";

  // ideal comparator: input at or above trial level
  assign cmp_ge = (ain >= trial_code);

  sar_conv_ctrl #(.WIDTH(W)) u_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .pwrdn(pwrdn),
    .cmp_ge(cmp_ge), .trial_code(trial_code), .busy_n(busy_n),
    .result(result), .result_strobe(result_strobe), .result_valid(result_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int         phase = 0;
  int         prev_sel = 1;
  int         done_cnt = 0;
  logic [W-1:0] held;
  logic [W-1:0] exp_result = '0;
  logic       exp_valid = 1'b0;
  bit         model_on = 0;
  int         res_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; prev_sel = 1;
    end else begin
      int sel;
      sel = (cs_n | rc_n) ? 1 : 0;
      if (phase == 0) begin
        if (prev_sel == 1 && sel == 0 && !pwrdn) begin
          phase = 1; held = ain; res_q.push_back(int'(ain));
        end
      end else if (phase == W + 2) phase = 0;
      else phase++;
      if (phase == W + 2) begin
        exp_result = W'(res_q.pop_front());
        exp_valid  = (done_cnt > 0);
        done_cnt++;
      end
      prev_sel = sel;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      check(ctx, "busy_n", busy_n, (phase == 0));
      check("R3", "result_strobe", result_strobe, (phase == W + 2));
      check("R9", "result", result, exp_result);
      check("R5", "result_valid", result_valid, exp_valid);
      if (phase == 1) check("R4", "first trial", trial_code, {1'b1, {(W-1){1'b0}}});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic convert(input logic [W-1:0] v, input bit rc_first);
    @(negedge clk);
    ain = v; cs_n = 1'b1; rc_n = 1'b1;
    cyc(2);
    if (rc_first) rc_n = 1'b0; else cs_n = 1'b0;
    cyc(2);
    if (rc_first) cs_n = 1'b0; else rc_n = 1'b0;
    cyc(3);
    cs_n = 1'b1; rc_n = 1'b1;
    cyc(W + 4);
    check("R4", "converted code", result, v);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rc_n = 1'b1; pwrdn = 1'b0; ain = '0;
    cyc(3);
    check("R8", "reset busy_n", busy_n, 1);
    check("R8", "reset strobe", result_strobe, 0);
    check("R8", "reset valid", result_valid, 0);
    check("R8", "reset result", result, 0);
    rst_n = 1'b1;
    cyc(4);
    model_on = 1;

    ctx = "R1";
    convert(16'h1234, 1'b0);
    check("R5", "first result invalid", result_valid, 0);
    convert(16'hFFFF, 1'b1);
    check("R5", "second result valid", result_valid, 1);
    ctx = "R2";
    convert(16'h0000, 1'b0);
    convert(16'h8000, 1'b1);
    convert(16'h7FFF, 1'b0);
    convert(16'h0001, 1'b1);

    // R7: extra select edges while busy
    ctx = "R7";
    @(negedge clk);
    ain = 16'hA5A5; cs_n = 1'b0; rc_n = 1'b1;
    cyc(1); rc_n = 1'b0;
    cyc(4); rc_n = 1'b1;
    cyc(2); rc_n = 1'b0;
    cyc(2); cs_n = 1'b1;
    cyc(2); cs_n = 1'b0;
    cyc(W + 6);
    check("R7", "busy idle after ignored edges", busy_n, 1);
    check("R7", "result from first start", result, 16'hA5A5);
    rc_n = 1'b1; cs_n = 1'b1;
    cyc(2);

    // R6: power-down blocks and keeps the result
    ctx = "R6";
    pwrdn = 1'b1; ain = 16'h0F0F;
    cyc(2); cs_n = 1'b0;
    cyc(2); rc_n = 1'b0;
    cyc(3);
    check("R6", "no start in power-down", busy_n, 1);
    rc_n = 1'b1; cyc(2); rc_n = 1'b0;
    cyc(2);
    pwrdn = 1'b0;
    cyc(W + 6);
    check("R6", "no start on release", busy_n, 1);
    check("R6", "result kept", result, 16'hA5A5);
    check("R6", "valid kept", result_valid, 1);
    cs_n = 1'b1; rc_n = 1'b1;

    ctx = "R1";
    convert(16'h5A3C, 1'b1);
    cyc(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule